// File: doc/BRIEF.md
# Shared-Multiplier FIR Filter

This block computes a 16-tap finite impulse response filter with one multiplier and one accumulator. The filter does not use one multiplier per tap. Instead it steps through the taps one per clock cycle. Each step multiplies a stored coefficient by the matching entry of a sample history and adds the product to a running sum. A three-state sequencer drives the shared coefficient address, the coefficient write enable and the accumulator clear.

After reset the sequencer is in a load pass. In that pass it writes one coefficient per cycle from `coef_in` into an internal coefficient store. After the store is full, it alternates between a one-cycle rearm step and a 16-cycle accumulate pass, and it never writes the store again.

Each rearm step does three things:
- It takes one new sample from `samp_in` into the sample history.
- It moves the finished sum to the output register.
- It clears the accumulator.

The block therefore accepts one input sample and produces one filtered output every 17 cycles. The surrounding logic uses the `take_sample` strobe to tell when a sample is consumed.

Top module: `tmux_fir`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `y` is 0 and both `y_vld` and `take_sample` are 0.
- R2: In cycle i after reset release (i = 0..15), the value on `coef_in` is stored as coefficient c[i]. Coefficient c[k] weights the sample that is k samples old.
- R3: `take_sample` is high in cycle 16 after reset release and then in every 17th cycle after it (16 + 17j). It is low in all other cycles.
- R4: The value on `samp_in` is captured only in a cycle where `take_sample` is high. Sample x[j] is the value captured at the j-th such cycle, counting from j = 0. Values present in other cycles have no effect.
- R5: `y_vld` is a one-cycle pulse in the cycle right after each `take_sample` cycle, starting with the second one (cycles 34, 51, 68, ...). The m-th pulse, counting from m = 0, carries y = sum over k of c[k]·x[m−k]. Missing history terms (m−k < 0) count as 0.
- R6: Values on `coef_in` after cycle 15 have no effect on any later output until the next reset.
- R7: The sum is formed in ACC_W-bit two's complement and wraps on overflow, with no saturation. Each product is a signed COEF_W+SAMP_W-bit value (12 bits by default).
- R8: Asserting reset at any point clears the sample history and the output, returns the block to the load pass, and the next 16 coefficients replace the old ones.
- R9: `y` keeps its value in every cycle where `y_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_in | input | COEF_W (6) | Signed coefficient, written during the load pass |
| samp_in | input | SAMP_W (6) | Signed sample, captured when `take_sample` is high |
| take_sample | output | 1 | High in the cycle whose `samp_in` is captured |
| y | output | ACC_W (18) | Signed filtered output, registered |
| y_vld | output | 1 | One-cycle strobe marking a new `y` |

## Verification
The first input pattern is a single unit impulse followed by zeros and then a few extreme samples. With this pattern, each of the first 16 outputs equals one coefficient, so a swapped tap order, a misplaced delay-line stage or an off-by-one capture cycle each shows up as a wrong value at a known output. The second pattern runs after a fresh reset. It uses all-minimum coefficients and samples, so the sum rises by 1024 per output. It is applied at the same time to a copy of the block built with a 14-bit accumulator, where the sum crosses the signed range and must wrap. This second pattern also shows whether a reset in the middle of a pass really reloads the coefficients. Throughout both runs, `coef_in` and `samp_in` carry changing junk outside their capture cycles, so any stray write or stray shift corrupts later outputs.

// File: rtl/tmux_fir_pkg.sv
package tmux_fir_pkg;

   // Sequencer phases: fill the coefficient store, one accumulate pass, one rearm step
   typedef enum logic [1:0] {
      ST_LOAD  = 2'd0,
      ST_STEP  = 2'd1,
      ST_REARM = 2'd2
   } seq_state_t;

endpackage

// File: rtl/tmux_fir_seq.sv
module tmux_fir_seq
   import tmux_fir_pkg::*;
#(
   parameter int TAPS = 16,
   parameter int AW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] addr,
   output logic          coef_we,
   output logic          acc_clr,
   output logic          take,
   output logic          last_step
);

   localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

   seq_state_t st_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_LOAD;
         addr_q <= '0;
      end else begin
         case (st_q)
            ST_LOAD, ST_STEP: begin
               if (addr_q == LAST) begin
                  st_q   <= ST_REARM;
                  addr_q <= '0;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            ST_REARM: begin
               st_q   <= ST_STEP;
               addr_q <= '0;
            end
            default: begin
               st_q   <= ST_LOAD;
               addr_q <= '0;
            end
         endcase
      end
   end

   assign addr      = addr_q;
   assign coef_we   = (st_q == ST_LOAD);
   assign acc_clr   = (st_q != ST_STEP);
   assign take      = (st_q == ST_REARM);
   assign last_step = (st_q == ST_STEP) && (addr_q == LAST);

endmodule

// File: rtl/tmux_fir_coef.sv
module tmux_fir_coef #(
   parameter int TAPS   = 16,
   parameter int COEF_W = 6,
   parameter int AW     = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            addr,
   input  logic signed [COEF_W-1:0] wdata,
   output logic signed [COEF_W-1:0] rdata
);

   logic signed [COEF_W-1:0] mem [TAPS];

   for (genvar k = 0; k < TAPS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[k] <= '0;
         end else if (we && (addr == AW'(k))) begin
            mem[k] <= wdata;
         end
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/tmux_fir_hist.sv
module tmux_fir_hist #(
   parameter int TAPS   = 16,
   parameter int SAMP_W = 6,
   parameter int AW     = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift,
   input  logic signed [SAMP_W-1:0] din,
   input  logic [AW-1:0]            addr,
   output logic signed [SAMP_W-1:0] dout
);

   // stage k holds the sample that is k samples old
   logic signed [SAMP_W-1:0] stage [TAPS];

   for (genvar k = 0; k < TAPS; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     stage[k] <= '0;
            else if (shift) stage[k] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     stage[k] <= '0;
            else if (shift) stage[k] <= stage[k-1];
         end
      end
   end

   assign dout = stage[addr];

endmodule

// File: rtl/tmux_fir_mac.sv
module tmux_fir_mac #(
   parameter int COEF_W = 6,
   parameter int SAMP_W = 6,
   parameter int PROD_W = 12,
   parameter int ACC_W  = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [COEF_W-1:0] coef,
   input  logic signed [SAMP_W-1:0] samp,
   input  logic                     acc_clr,
   input  logic                     last_step,
   input  logic                     take,
   output logic signed [ACC_W-1:0]  y,
   output logic                     y_vld
);

   localparam int FULL_W = COEF_W + SAMP_W;

   logic signed [FULL_W-1:0] full_p;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_ext;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [ACC_W-1:0]  acc_nxt;
   logic                     pass_done_q;

   assign full_p = coef * samp;

   // product width variant: keep every bit, or keep the low PROD_W bits
   if (PROD_W >= FULL_W) begin : g_prod_full
      assign prod = PROD_W'(full_p);
   end else begin : g_prod_cut
      assign prod = full_p[PROD_W-1:0];
   end

   assign prod_ext = ACC_W'(prod);
   assign acc_nxt  = acc_clr ? '0 : (acc_q + prod_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_nxt;
   end

   // a sum is ready only once a whole accumulate pass has run
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pass_done_q <= 1'b0;
      else if (last_step) pass_done_q <= 1'b1;
      else if (take)      pass_done_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y     <= '0;
         y_vld <= 1'b0;
      end else begin
         y_vld <= take && pass_done_q;
         if (take && pass_done_q) y <= acc_q;
      end
   end

endmodule

// File: rtl/tmux_fir.sv
module tmux_fir #(
   parameter int TAPS   = 16,
   parameter int COEF_W = 6,
   parameter int SAMP_W = 6,
   parameter int PROD_W = 12,
   parameter int ACC_W  = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [COEF_W-1:0] coef_in,
   input  logic signed [SAMP_W-1:0] samp_in,
   output logic                     take_sample,
   output logic signed [ACC_W-1:0]  y,
   output logic                     y_vld
);

   localparam int AW = (TAPS > 1) ? $clog2(TAPS) : 1;

   if (TAPS < 2) begin : g_bad_taps
      $error("tmux_fir: TAPS must be at least 2");
   end
   if (ACC_W <= PROD_W) begin : g_bad_acc
      $error("tmux_fir: ACC_W must exceed PROD_W");
   end
   if (COEF_W < 2 || SAMP_W < 2) begin : g_bad_in
      $error("tmux_fir: operand widths must be at least 2");
   end

   logic [AW-1:0]            addr;
   logic                     coef_we;
   logic                     acc_clr;
   logic                     last_step;
   logic signed [COEF_W-1:0] coef_rd;
   logic signed [SAMP_W-1:0] samp_rd;

   tmux_fir_seq #(.TAPS(TAPS), .AW(AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .coef_we   (coef_we),
      .acc_clr   (acc_clr),
      .take      (take_sample),
      .last_step (last_step)
   );

   tmux_fir_coef #(.TAPS(TAPS), .COEF_W(COEF_W), .AW(AW)) u_coef (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (coef_we),
      .addr  (addr),
      .wdata (coef_in),
      .rdata (coef_rd)
   );

   tmux_fir_hist #(.TAPS(TAPS), .SAMP_W(SAMP_W), .AW(AW)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (take_sample),
      .din   (samp_in),
      .addr  (addr),
      .dout  (samp_rd)
   );

   tmux_fir_mac #(.COEF_W(COEF_W), .SAMP_W(SAMP_W), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .coef      (coef_rd),
      .samp      (samp_rd),
      .acc_clr   (acc_clr),
      .last_step (last_step),
      .take      (take_sample),
      .y         (y),
      .y_vld     (y_vld)
   );

endmodule

// File: rtl/tmux_fir_chk.sv
module tmux_fir_chk #(
   parameter int TAPS  = 16,
   parameter int ACC_W = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             coef_we,
   input logic             take_sample,
   input logic             y_vld,
   input logic [ACC_W-1:0] y
);

   logic [31:0] cyc;
   logic [31:0] gap;
   logic        seen_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc       <= '0;
         gap       <= '0;
         seen_take <= 1'b0;
      end else begin
         if (cyc != 32'hFFFF_FFFF) cyc <= cyc + 1'b1;
         if (take_sample) begin
            gap       <= '0;
            seen_take <= 1'b1;
         end else if (gap != 32'hFFFF_FFFF) begin
            gap <= gap + 1'b1;
         end
      end
   end

   assert_no_vld_in_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      coef_we |-> !y_vld);

   assert_first_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_sample && !seen_take) |-> (cyc == 32'(TAPS)));

   assert_rearm_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_sample && seen_take) |-> (gap == 32'(TAPS)));

   assert_vld_after_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      y_vld |-> $past(take_sample));

   assert_single_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_sample |=> !take_sample);

   assert_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      seen_take |-> !coef_we);

   assert_y_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !y_vld |-> $stable(y));

endmodule

bind tmux_fir tmux_fir_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .coef_we     (coef_we),
   .take_sample (take_sample),
   .y_vld       (y_vld),
   .y           (y)
);

// File: tb/test_tmux_fir.sv
`timescale 1ns/1ps
module test_tmux_fir;

   localparam int TAPS = 16;
   localparam int CW   = 6;
   localparam int SW   = 6;
   localparam int NF   = 20;
   localparam int PER  = TAPS + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [CW-1:0] coef_in = '0;
   logic signed [SW-1:0] samp_in = '0;
   logic        take, take_w, vld, vld_w;
   logic [17:0] y;
   logic [13:0] yw;

   int     cf [TAPS];
   int     xs [NF];
   int     checks = 0;
   int     errors = 0;
   bit     done = 1'b0;
   longint last_y, last_yw;

   always #2 clk = ~clk;

   tmux_fir i_tmux_fir (
      .clk(clk), .rst_n(rst_n), .coef_in(coef_in), .samp_in(samp_in),
      .take_sample(take), .y(y), .y_vld(vld));

   // narrow-accumulator copy used for the wrap requirement
   tmux_fir #(.ACC_W(14)) i_tmux_fir_w (
      .clk(clk), .rst_n(rst_n), .coef_in(coef_in), .samp_in(samp_in),
      .take_sample(take_w), .y(yw), .y_vld(vld_w));

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint wrapv(longint s, int w);
      longint r;
      r = s <<< (64 - w);
      return r >>> (64 - w);
   endfunction

   function automatic longint refy(int m, int w);
      longint s = 0;
      for (int k = 0; k < TAPS; k++) begin
         if (m - k >= 0 && m - k < NF) s += longint'(cf[k]) * longint'(xs[m-k]);
      end
      return wrapv(s, w);
   endfunction

   function automatic bit exp_take(int i);
      return (i >= TAPS) && ((i - TAPS) % PER == 0);
   endfunction

   function automatic bit exp_vld(int i);
      return (i >= 2 * PER) && (i % PER == 0);
   endfunction

   task automatic check_cycle(int i, string tag);
      int     m;
      longint e, ew;
      if (i == 0) begin
         chk("R1 y after reset", longint'($signed(y)), 0);
         chk("R1 y_vld after reset", longint'(vld), 0);
         chk("R1 take_sample after reset", longint'(take), 0);
      end
      chk("R3 take_sample timing", longint'(take), longint'(exp_take(i)));
      chk("R3 take_sample timing narrow", longint'(take_w), longint'(exp_take(i)));
      chk("R5 y_vld timing", longint'(vld), longint'(exp_vld(i)));
      chk("R5 y_vld timing narrow", longint'(vld_w), longint'(exp_vld(i)));
      if (exp_vld(i)) begin
         m  = i / PER - 2;
         e  = refy(m, 18);
         ew = refy(m, 14);
         chk({"R5 filtered value ", tag}, longint'($signed(y)), e);
         chk({"R7 wrapped value ", tag}, longint'($signed(yw)), ew);
         last_y  = e;
         last_yw = ew;
      end else begin
         chk("R9 y held", longint'($signed(y)), last_y);
         chk("R9 y held narrow", longint'($signed(yw)), last_yw);
      end
   endtask

   // junk on coef_in after load (R6) and on samp_in outside capture (R4)
   task automatic drive_cycle(int i);
      int j;
      if (i < TAPS) coef_in = CW'(cf[i]);
      else          coef_in = CW'(i * 13 + 5);
      if (exp_take(i)) begin
         j = (i - TAPS) / PER;
         samp_in = (j < NF) ? SW'(xs[j]) : SW'(0);
      end else begin
         samp_in = SW'(i * 7 + 3);
      end
   endtask

   task automatic run_phase(string tag);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n   = 1'b1;
      last_y  = 0;
      last_yw = 0;
      for (int i = 0; i <= PER * (NF + 1) + 5; i++) begin
         if (i > 0) @(negedge clk);
         check_cycle(i, tag);
         drive_cycle(i);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      // phase 1: impulse reveals tap order (R2, R4), then extreme samples
      for (int k = 0; k < TAPS; k++) cf[k] = ((k * 5) % 23) - 11;
      for (int j = 0; j < NF; j++) xs[j] = 0;
      xs[0] = 1; xs[16] = -32; xs[17] = 31; xs[18] = 5; xs[19] = -7;
      run_phase("R2 R4 R6");
      // phase 2: reset mid-pass, reload, ramp that wraps the narrow copy
      for (int k = 0; k < TAPS; k++) cf[k] = -32;
      for (int j = 0; j < NF; j++) xs[j] = -32;
      run_phase("R8 R7 reload");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule